// File: doc/BRIEF.md
# Combinational Successive-Cancellation Polar Decoder

This block turns one polar codeword of length N = 2^M into N bit estimates. Each estimate comes from successive-cancellation decoding of N channel log-likelihood ratios (LLRs). The whole decoding tree is unrolled into a single combinational cone. There is no scheduler, no controller and no LLR memory. One register stage captures a codeword and a second captures the decisions, so a new codeword can enter on every clock.

Each LLR is W bits wide and in sign-magnitude form. The sign is the top bit, and a 1 there means negative. The low W-1 bits are the magnitude. LLR i sits at bits [i*W +: W] of the input vector.

A frozen mask arrives with every codeword, one bit per position. The code rate can therefore change from one codeword to the next.

The tree is built recursively from a length-4 leaf unit. Every node splits its LLRs into a first half and a second half. The left child receives the min-sum combination of LLRs i and i+N/2. The right child receives the partial-sum-steered sum or difference of the same pair.

Top module: `polar_sc_decoder`

## Requirements
- R1: The min-sum node outputs the XOR of the two input signs as its sign. Its magnitude is the smaller of the two input magnitudes.
- R2: The sum node outputs b+a when its partial-sum bit is 0 and b-a when it is 1. Here a is the first-half LLR and b is the second-half LLR. The result is clamped to ±(2^(W-1)-1), and a zero result has sign 0.
- R3: A decision is 1 only when the final LLR has sign bit 1 and a nonzero magnitude. A position whose frozen-mask bit is 1 is forced to 0.
- R4: Bit i of the output vector equals u_i of successive-cancellation decoding with the split described above. The partial sums steering a right subtree are the polar encoding of the left subtree's decisions: the first half is left XOR right and the second half is right.
- R5: The output valid flag rises exactly two rising edges after the input valid is sampled high. The matching decision vector is on the output in that same cycle.
- R6: Codewords may arrive on consecutive cycles, each with a different frozen mask. Each result depends only on its own LLRs and mask.
- R7: In a cycle with no new result, the output valid flag is low and the decision vector keeps its last value, whatever the LLR and mask inputs carry.
- R8: While the active-low reset is asserted, the output valid flag and the decision vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid_i | input | 1 | Codeword present on this cycle |
| cw_llr_i | input | N*W | Channel LLRs, sign-magnitude, position i at [i*W +: W] |
| cw_frozen_i | input | N | Frozen mask, bit i = 1 freezes position i |
| dec_valid_o | output | 1 | Decision vector is new this cycle |
| dec_bits_o | output | N | Decided bits, bit i = u_i |

## Verification
Two things can fall in the same clock edge. One is the capture of a new codeword and its frozen mask into the input register. The other is the registering of the previous codeword's decisions. The bench provokes this by streaming codewords back to back, with the mask changing on every one. That includes the same strong LLR vector sent first with no frozen positions and then fully frozen. Each output is judged by comparing it, in order, against a behavioural successive-cancellation model run in the bench, so any leakage of one codeword's mask or LLRs into its neighbour shows up as a mismatch.

// File: rtl/polar_sc_pkg.sv
package polar_sc_pkg;

  // Hard decision on a sign-magnitude LLR, with frozen forcing.
  function automatic logic hard_bit(input logic sgn, input logic mag_nz, input logic frz);
    return ~frz & sgn & mag_nz;
  endfunction

endpackage

// File: rtl/polar_f_layer.sv
module polar_f_layer #(
  parameter int W = 6,
  parameter int K = 1
) (
  input  logic [K*W-1:0] a_i,
  input  logic [K*W-1:0] b_i,
  output logic [K*W-1:0] o_o
);

  localparam int MW = W - 1;

  for (genvar k = 0; k < K; k++) begin : g_elem
    logic [MW-1:0] ma, mb, mo;
    logic          so;

    assign ma = a_i[k*W +: MW];
    assign mb = b_i[k*W +: MW];

    always_comb begin
      so = a_i[k*W+MW] ^ b_i[k*W+MW];
      mo = (ma < mb) ? ma : mb;
    end

    assign o_o[k*W +: W] = {so, mo};

    always_comb begin
      if (!$isunknown({a_i[k*W +: W], b_i[k*W +: W]})) begin
        AST_F_ZERO_MAG: assert ((o_o[k*W +: MW] == '0) == ((ma == '0) || (mb == '0)))
          else $error("min-sum magnitude zero mismatch"); // R1
      end
    end
  end

endmodule

// File: rtl/polar_g_layer.sv
module polar_g_layer #(
  parameter int W = 6,
  parameter int K = 1
) (
  input  logic [K*W-1:0] a_i,
  input  logic [K*W-1:0] b_i,
  input  logic [K-1:0]   ps_i,
  output logic [K*W-1:0] o_o
);

  localparam int MW = W - 1;
  localparam logic signed [W:0] LIM_P = $signed({2'b00, {MW{1'b1}}});
  localparam logic signed [W:0] LIM_N = -LIM_P;

  for (genvar k = 0; k < K; k++) begin : g_elem
    logic signed [W:0] va, vb, vsum, vsat, vabs;
    logic              neg;

    always_comb begin
      va   = a_i[k*W+MW] ? -$signed({2'b00, a_i[k*W +: MW]}) : $signed({2'b00, a_i[k*W +: MW]});
      vb   = b_i[k*W+MW] ? -$signed({2'b00, b_i[k*W +: MW]}) : $signed({2'b00, b_i[k*W +: MW]});
      vsum = ps_i[k] ? (vb - va) : (vb + va);
      if (vsum > LIM_P)      vsat = LIM_P;
      else if (vsum < LIM_N) vsat = LIM_N;
      else                   vsat = vsum;
      neg  = vsat[W];
      vabs = neg ? -vsat : vsat;
    end

    assign o_o[k*W +: W] = {neg, vabs[MW-1:0]};

    always_comb begin
      if (!$isunknown({a_i[k*W +: W], b_i[k*W +: W], ps_i[k]})) begin
        AST_G_SAME_SIGN: assert (!(!ps_i[k] && !a_i[k*W+MW] && !b_i[k*W+MW]) || !o_o[k*W+MW])
          else $error("sum of two non-negative LLRs came out negative"); // R2
      end
    end
  end

endmodule

// File: rtl/polar_sc_base4.sv
module polar_sc_base4 #(
  parameter int W = 6
) (
  input  logic [4*W-1:0] llr_i,
  input  logic [3:0]     frz_i,
  output logic [3:0]     u_o,
  output logic [3:0]     x_o
);

  import polar_sc_pkg::*;

  logic [2*W-1:0] lay_f, lay_g;
  logic [W-1:0]   l0, l1, l2, l3;
  logic [1:0]     ps_left;
  logic [3:0]     u;

  // first layer, left branch
  polar_f_layer #(.W(W), .K(2)) u_f_top (
    .a_i(llr_i[2*W-1:0]), .b_i(llr_i[4*W-1:2*W]), .o_o(lay_f));

  polar_f_layer #(.W(W), .K(1)) u_f_l0 (
    .a_i(lay_f[W-1:0]), .b_i(lay_f[2*W-1:W]), .o_o(l0));
  assign u[0] = hard_bit(l0[W-1], |l0[W-2:0], frz_i[0]);

  polar_g_layer #(.W(W), .K(1)) u_g_l1 (
    .a_i(lay_f[W-1:0]), .b_i(lay_f[2*W-1:W]), .ps_i(u[0]), .o_o(l1));
  assign u[1] = hard_bit(l1[W-1], |l1[W-2:0], frz_i[1]);

  // partial sums of the left pair
  assign ps_left = {u[1], u[0] ^ u[1]};

  // first layer, right branch
  polar_g_layer #(.W(W), .K(2)) u_g_top (
    .a_i(llr_i[2*W-1:0]), .b_i(llr_i[4*W-1:2*W]), .ps_i(ps_left), .o_o(lay_g));

  polar_f_layer #(.W(W), .K(1)) u_f_l2 (
    .a_i(lay_g[W-1:0]), .b_i(lay_g[2*W-1:W]), .o_o(l2));
  assign u[2] = hard_bit(l2[W-1], |l2[W-2:0], frz_i[2]);

  polar_g_layer #(.W(W), .K(1)) u_g_l3 (
    .a_i(lay_g[W-1:0]), .b_i(lay_g[2*W-1:W]), .ps_i(u[2]), .o_o(l3));
  assign u[3] = hard_bit(l3[W-1], |l3[W-2:0], frz_i[3]);

  assign u_o = u;
  assign x_o = {u[3], u[2] ^ u[3], u[1] ^ u[3], u[0] ^ u[1] ^ u[2] ^ u[3]};

endmodule

// File: rtl/polar_sc_tree.sv
module polar_sc_tree #(
  parameter int W = 6,
  parameter int L = 3
) (
  input  logic [(1<<L)*W-1:0] llr_i,
  input  logic [(1<<L)-1:0]   frz_i,
  output logic [(1<<L)-1:0]   u_o,
  output logic [(1<<L)-1:0]   x_o
);

  localparam int N = 1 << L;
  localparam int H = N / 2;

  if (L <= 2) begin : g_leaf
    polar_sc_base4 #(.W(W)) u_base (
      .llr_i(llr_i), .frz_i(frz_i), .u_o(u_o), .x_o(x_o));
  end else begin : g_split
    logic [H*W-1:0] llr_l, llr_r;
    logic [H-1:0]   u_l, u_r, x_l, x_r;

    polar_f_layer #(.W(W), .K(H)) u_f (
      .a_i(llr_i[H*W-1:0]), .b_i(llr_i[N*W-1:H*W]), .o_o(llr_l));

    polar_sc_tree #(.W(W), .L(L-1)) u_left (
      .llr_i(llr_l), .frz_i(frz_i[H-1:0]), .u_o(u_l), .x_o(x_l));

    polar_g_layer #(.W(W), .K(H)) u_g (
      .a_i(llr_i[H*W-1:0]), .b_i(llr_i[N*W-1:H*W]), .ps_i(x_l), .o_o(llr_r));

    polar_sc_tree #(.W(W), .L(L-1)) u_right (
      .llr_i(llr_r), .frz_i(frz_i[N-1:H]), .u_o(u_r), .x_o(x_r));

    assign u_o = {u_r, u_l};
    assign x_o = {x_r, x_l ^ x_r};
  end

endmodule

// File: rtl/polar_sc_decoder.sv
module polar_sc_decoder #(
  parameter int W = 6,
  parameter int M = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cw_valid_i,
  input  logic [(1<<M)*W-1:0]    cw_llr_i,
  input  logic [(1<<M)-1:0]      cw_frozen_i,
  output logic                   dec_valid_o,
  output logic [(1<<M)-1:0]      dec_bits_o
);

  localparam int N = 1 << M;

  logic [N*W-1:0] llr_q, llr_d;
  logic [N-1:0]   frz_q, frz_d;
  logic           stage_vld_q;
  logic           out_vld_q;
  logic [N-1:0]   out_bits_q, out_bits_d;
  logic [N-1:0]   dec_bits, cw_x;

  // input capture, enabled by the valid strobe
  always_comb begin
    llr_d = cw_valid_i ? cw_llr_i    : llr_q;
    frz_d = cw_valid_i ? cw_frozen_i : frz_q;
  end

  always_ff @(posedge clk) begin
    llr_q <= llr_d;
    frz_q <= frz_d;
  end

  polar_sc_tree #(.W(W), .L(M)) u_tree (
    .llr_i(llr_q), .frz_i(frz_q), .u_o(dec_bits), .x_o(cw_x));

  // output capture, enabled by the stage valid
  always_comb begin
    out_bits_d = stage_vld_q ? dec_bits : out_bits_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_vld_q <= 1'b0;
      out_vld_q   <= 1'b0;
      out_bits_q  <= '0;
    end else begin
      stage_vld_q <= cw_valid_i;
      out_vld_q   <= stage_vld_q;
      out_bits_q  <= out_bits_d;
    end
  end

  assign dec_valid_o = out_vld_q;
  assign dec_bits_o  = out_bits_q;

  // re-encoding the partial-sum codeword must give back the decisions
  logic [N-1:0] reenc;
  always_comb begin
    reenc = cw_x;
    for (int s = 0; s < M; s++) begin
      for (int i = 0; i < N; i++) begin
        if ((i & (1 << s)) == 0) reenc[i] = reenc[i] ^ reenc[i + (1 << s)];
      end
    end
  end

  AST_PSUM_INVOLUTION: assert property (@(posedge clk) disable iff (!rst_n)
    stage_vld_q |-> (reenc == dec_bits)) else $error("partial sums disagree with decisions"); // R4

  AST_FROZEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> ((dec_bits_o & $past(frz_q)) == '0)) else $error("frozen bit decided as 1"); // R3

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid_i |-> ##2 dec_valid_o) else $error("valid latency wrong"); // R5

  AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid_o) |-> $past(cw_valid_i, 2)) else $error("spurious valid"); // R5

  AST_HOLD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_vld_q |=> ($stable(dec_bits_o) && !dec_valid_o)) else $error("output moved without result"); // R7

endmodule

// File: tb/polar_sc_decoder_bench.sv
module polar_sc_decoder_bench;

  localparam int W = 6;
  localparam int M = 3;
  localparam int N = 1 << M;
  localparam int MAXM = (1 << (W - 1)) - 1;
  localparam int TAB_N = 6;

  // {llr, frozen mask, expected bits}
  localparam logic [N*W+2*N-1:0] TAB [TAB_N] = '{
    {{8{6'h1F}}, 8'h00, 8'h00},              // R2: all strong positive, sums saturate
    {{8{6'h3F}}, 8'h00, 8'h80},              // R4: all strong negative decodes to u7 only
    {{8{6'h3F}}, 8'hFF, 8'h00},              // R6: same LLRs, all frozen, back to back
    {{8{6'h20}}, 8'h00, 8'h00},              // R3: negative zero decodes to 0
    {{{7{6'h1F}}, 6'h3F}, 8'h00, 8'h01},     // R1: one negative sign flips min-sum of u0
    {{8{6'h3F}}, 8'h7F, 8'h80}               // R3: frozen positions forced to 0
  };
  localparam string TAB_REQ [TAB_N] = '{"R2", "R4", "R6", "R3", "R1", "R3"};

  logic           clk;
  logic           rst_n;
  logic           cw_valid_i;
  logic [N*W-1:0] cw_llr_i;
  logic [N-1:0]   cw_frozen_i;
  logic           dec_valid_o;
  logic [N-1:0]   dec_bits_o;

  int checks;
  int errors;
  bit done;

  logic [N*W-1:0] s_llr [64];
  logic [N-1:0]   s_frz [64];
  logic [N-1:0]   s_exp [64];
  string          s_req [64];
  int             s_cnt;

  polar_sc_decoder #(.W(W), .M(M)) u_polar_sc_decoder (
    .clk(clk), .rst_n(rst_n), .cw_valid_i(cw_valid_i), .cw_llr_i(cw_llr_i),
    .cw_frozen_i(cw_frozen_i), .dec_valid_o(dec_valid_o), .dec_bits_o(dec_bits_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sm2i(input logic [W-1:0] v);
    int mag;
    mag = int'(v[W-2:0]);
    return v[W-1] ? -mag : mag;
  endfunction

  function automatic int fmin(input int a, input int b);
    int ma, mb, m;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    m  = (ma < mb) ? ma : mb;
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

  function automatic int gsum(input int a, input int b, input bit ps);
    int r;
    r = ps ? (b - a) : (b + a);
    if (r > MAXM)  r = MAXM;
    if (r < -MAXM) r = -MAXM;
    return r;
  endfunction

  // behavioural successive cancellation, bit by bit
  function automatic logic [N-1:0] sc_model(input logic [N*W-1:0] llr, input logic [N-1:0] frz);
    int   alpha [M+1][N];
    bit   beta  [M+1][N];
    logic [N-1:0] u;
    u = '0;
    for (int i = 0; i < N; i++) alpha[M][i] = sm2i(llr[i*W +: W]);
    for (int i = 0; i < N; i++) begin
      for (int l = M - 1; l >= 0; l--) begin
        int s, h;
        h = 1 << l;
        s = i & ~((2 << l) - 1);
        if (((i >> l) & 1) == 0) begin
          for (int k = 0; k < h; k++) alpha[l][s+k] = fmin(alpha[l+1][s+k], alpha[l+1][s+h+k]);
        end else begin
          for (int k = 0; k < h; k++)
            alpha[l][s+h+k] = gsum(alpha[l+1][s+k], alpha[l+1][s+h+k], beta[l][s+k]);
        end
      end
      u[i] = frz[i] ? 1'b0 : (alpha[0][i] < 0);
      beta[0][i] = u[i];
      for (int l = 0; l < M; l++) begin
        int s, h;
        if (((i >> l) & 1) == 0) break;
        h = 1 << l;
        s = i & ~((2 << l) - 1);
        for (int k = 0; k < h; k++) begin
          beta[l+1][s+k]   = beta[l][s+k] ^ beta[l][s+h+k];
          beta[l+1][s+h+k] = beta[l][s+h+k];
        end
      end
    end
    return u;
  endfunction

  // drive s_cnt codewords back to back, check each result two edges later
  task automatic run_stream();
    for (int c = 0; c < s_cnt + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        chk(dec_valid_o == 1'b1, "R5 valid after two edges", 64'(dec_valid_o), 64'd1);
        chk(dec_bits_o == s_exp[c-2], s_req[c-2], 64'(dec_bits_o), 64'(s_exp[c-2]));
      end else begin
        chk(dec_valid_o == 1'b0, "R5 no early valid", 64'(dec_valid_o), 64'd0);
      end
      if (c < s_cnt) begin
        cw_valid_i  = 1'b1;
        cw_llr_i    = s_llr[c];
        cw_frozen_i = s_frz[c];
      end else begin
        cw_valid_i  = 1'b0;
      end
    end
  endtask

  function automatic logic [N*W-1:0] rand_llr();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom_range(0, (1 << W) - 1));
    return v;
  endfunction

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; cw_valid_i = 1'b0; cw_llr_i = '0; cw_frozen_i = '0;
    repeat (3) @(negedge clk);
    chk(dec_valid_o == 1'b0, "R8 valid in reset", 64'(dec_valid_o), 64'd0);
    chk(dec_bits_o == '0, "R8 bits in reset", 64'(dec_bits_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of directed vectors, streamed back to back
    for (int t = 0; t < TAB_N; t++) begin
      s_llr[t] = TAB[t][N*W+2*N-1 -: N*W];
      s_frz[t] = TAB[t][2*N-1 -: N];
      s_exp[t] = TAB[t][N-1:0];
      s_req[t] = {TAB_REQ[t], " table vector"};
    end
    s_cnt = TAB_N;
    run_stream();

    // R7: no new result, inputs toggle, outputs hold
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      cw_llr_i = rand_llr();
      cw_frozen_i = N'($urandom());
      chk(dec_valid_o == 1'b0, "R7 valid low when idle", 64'(dec_valid_o), 64'd0);
      chk(dec_bits_o == 8'h80, "R7 bits hold when idle", 64'(dec_bits_o), 64'h80);
    end

    // R4/R6: random codewords with a fresh mask each cycle
    for (int r = 0; r < 3; r++) begin
      s_cnt = 40;
      for (int c = 0; c < s_cnt; c++) begin
        s_llr[c] = rand_llr();
        s_frz[c] = (r == 0) ? N'($urandom()) : ((r == 1) ? N'($urandom() & $urandom()) : '0);
        s_exp[c] = sc_model(s_llr[c], s_frz[c]);
        s_req[c] = "R4 random vs model (R6 mask per codeword)";
      end
      run_stream();
    end

    // single codewords with gaps in between
    for (int r = 0; r < 10; r++) begin
      s_cnt = 1;
      s_llr[0] = rand_llr();
      s_frz[0] = N'($urandom());
      s_exp[0] = sc_model(s_llr[0], s_frz[0]);
      s_req[0] = "R4 isolated codeword";
      run_stream();
      @(negedge clk);
    end

    // R8: reset during operation, after a nonzero result
    s_cnt = 1;
    s_llr[0] = {8{6'h3F}}; s_frz[0] = '0; s_exp[0] = 8'h80; s_req[0] = "R4 before reset";
    run_stream();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(dec_bits_o == '0, "R8 bits cleared by reset", 64'(dec_bits_o), 64'd0);
    chk(dec_valid_o == 1'b0, "R8 valid cleared by reset", 64'(dec_valid_o), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule